// File: doc/BRIEF.md
# Compare-Match Timer

This block is a 32-bit up-counting timer placed on a simple register bus. Software selects one of three tick sources, sets two prescale stages, loads a compare value and enables the timer. Each qualified tick advances the counter. When the counter reaches the compare value, a sticky status flag sets. If the matching enable bit is set, a registered level interrupt follows the flag.

Ticks arrive as single-cycle enable pulses on three inputs: bus clock, peripheral clock and oscillator. They are not real clocks, so the whole block runs on one clock. The oscillator path has its own small divider. When its prescaler is turned off, that divider stays at a fixed divide-by-8. A 12-bit main prescaler then divides whichever source is selected. In restart mode the counter returns to zero after a match. In free-run mode it keeps counting and wraps naturally.

The bus uses byte offsets. Writes take effect at the clock edge where `bus_we` is high. Read data is registered: `bus_rdata` shows, one cycle later, the register selected by `bus_addr`.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: The counter and both prescaler counters advance only while control bit 0 (enable) is 1. Clearing it holds all three at their current values, and setting it again resumes from those values.
- R3: Control bits 8:6 select the tick source. Code 1 selects `tick_bus`, code 2 selects `tick_per` and code 5 selects the oscillator path. Any other code produces no counting.
- R4: Prescaler register bits 11:0 (offset 0x04) divide the selected source by value+1. A value of 0 passes every tick.
- R5: The oscillator path divides `tick_osc` by 8 when control bit 10 is 0. When control bit 10 is 1, it divides by prescaler bits 15:12 plus 1, so a field value of 7 also gives divide-by-8.
- R6: With control bit 9 set (free-run), the counter counts on past the compare value, incrementing by one per qualified tick.
- R7: With control bit 9 clear (restart), the first qualified tick after the counter equals the compare value (offset 0x10) loads the counter with 0.
- R8: Status bit 0 (offset 0x08) sets on the tick that brings the counter to the compare value. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R9: `irq` equals status bit 0 AND interrupt-enable bit 0 (offset 0x0C), delayed by one register. Clearing the enable masks `irq` but does not clear the flag.
- R10: The counter (offset 0x24) is read-only and reading it does not change it. Offsets with no register read as 0.
- R11: Control (offset 0x00) stores bits 0, 3, 6–10 and reads the rest as 0. The prescaler stores bits 15:0. Bit 3 (wait enable) has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_bus | input | 1 | Bus-clock tick enable |
| tick_per | input | 1 | Peripheral-clock tick enable |
| tick_osc | input | 1 | Oscillator tick enable |
| irq | output | 1 | Level compare interrupt |

## Verification
The assertions assume that the tick inputs are synchronous single-cycle enables sampled on `clk`. They also assume that a compare write landing on the same edge as a match is resolved by the old compare value, so they check restart and flag-set behaviour against values sampled at the tick edge. The stimulus changes ticks and bus signals only on the falling edge. It also keeps all tick inputs low while registers are written, so every counted tick falls within a known window.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_PRE  = 'h04;
  localparam int OFF_STAT = 'h08;
  localparam int OFF_IEN  = 'h0C;
  localparam int OFF_CMP  = 'h10;
  localparam int OFF_CNT  = 'h24;

  localparam int CTL_EN   = 0;
  localparam int CTL_WAIT = 3;
  localparam int CTL_SRC  = 6;   // 3-bit field, low bit
  localparam int CTL_FRUN = 9;
  localparam int CTL_OPEN = 10;

  localparam logic [2:0] SRC_BUS  = 3'd1;
  localparam logic [2:0] SRC_PER  = 3'd2;
  localparam logic [2:0] SRC_OSC  = 3'd5;

  localparam int OSC_FIXED_DIV = 8;
endpackage

// File: rtl/mt_divider.sv
module mt_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick_in,
  input  logic [W-1:0] div,
  output logic         tick_out
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap     = (cnt_q >= div);
  assign tick_out = run && tick_in && wrap;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (run && tick_in)
      cnt_q <= wrap ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/mt_count.sv
module mt_count #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic [DW-1:0] cmp,
  output logic [DW-1:0] cnt,
  output logic          hit
);
  logic [DW-1:0] nxt;

  always_comb begin
    if (restart && cnt == cmp) nxt = '0;
    else                       nxt = cnt + DW'(1);
  end

  assign hit = tick && (nxt == cmp);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= nxt;
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 6,
  parameter int MPW = 12,
  parameter int OPW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_bus,
  input  logic          tick_per,
  input  logic          tick_osc,
  output logic          irq
);
  localparam logic [DW-1:0] CTRL_MASK = DW'((1 << CTL_EN) | (1 << CTL_WAIT) |
                                            (7 << CTL_SRC) | (1 << CTL_FRUN) |
                                            (1 << CTL_OPEN));
  localparam logic [DW-1:0] PRE_MASK  = DW'((1 << (MPW + OPW)) - 1);
  localparam logic [OPW-1:0] OSC_FIX  = OPW'(OSC_FIXED_DIV - 1);

  logic [DW-1:0] ctrl_q, pre_q, cmp_q, cnt_w, rd_d;
  logic          ien_q, flag_q, irq_q;
  logic          en, frun, osc_pen;
  logic [2:0]    src_sel;
  logic          osc_tick, src_tick, main_tick, hit;
  logic [OPW-1:0] osc_div;
  logic          wr_stat;

  assign en      = ctrl_q[CTL_EN];
  assign frun    = ctrl_q[CTL_FRUN];
  assign osc_pen = ctrl_q[CTL_OPEN];
  assign src_sel = ctrl_q[CTL_SRC +: 3];
  assign osc_div = osc_pen ? pre_q[MPW +: OPW] : OSC_FIX;

  // Oscillator stage: runs only while the oscillator source is selected
  mt_divider #(.W(OPW)) u_osc_div (
    .clk(clk), .rst(rst), .run(en && src_sel == SRC_OSC),
    .tick_in(tick_osc), .div(osc_div), .tick_out(osc_tick)
  );

  always_comb begin
    case (src_sel)
      SRC_BUS: src_tick = tick_bus;
      SRC_PER: src_tick = tick_per;
      SRC_OSC: src_tick = osc_tick;
      default: src_tick = 1'b0;
    endcase
  end

  mt_divider #(.W(MPW)) u_main_div (
    .clk(clk), .rst(rst), .run(en), .tick_in(src_tick),
    .div(pre_q[MPW-1:0]), .tick_out(main_tick)
  );

  mt_count #(.DW(DW)) u_count (
    .clk(clk), .rst(rst), .tick(main_tick), .restart(!frun),
    .cmp(cmp_q), .cnt(cnt_w), .hit(hit)
  );

  // Register file
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      cmp_q  <= '0;
      ien_q  <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        AW'(OFF_CTRL): ctrl_q <= bus_wdata & CTRL_MASK;
        AW'(OFF_PRE):  pre_q  <= bus_wdata & PRE_MASK;
        AW'(OFF_IEN):  ien_q  <= bus_wdata[0];
        AW'(OFF_CMP):  cmp_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign wr_stat = bus_we && bus_addr == AW'(OFF_STAT) && bus_wdata[0];

  // Sticky flag: set has priority over write-one-to-clear
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (hit)     flag_q <= 1'b1;
    else if (wr_stat) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_q && ien_q;
  end
  assign irq = irq_q;

  always_comb begin
    case (bus_addr)
      AW'(OFF_CTRL): rd_d = ctrl_q;
      AW'(OFF_PRE):  rd_d = pre_q;
      AW'(OFF_STAT): rd_d = DW'(flag_q);
      AW'(OFF_IEN):  rd_d = DW'(ien_q);
      AW'(OFF_CMP):  rd_d = cmp_q;
      AW'(OFF_CNT):  rd_d = cnt_w;
      default:       rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          frun,
  input logic          ien,
  input logic          tick,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] cmp,
  input logic          flag,
  input logic          irq
);
  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));
  // R10
  no_tick_no_move_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  // R6
  freerun_step_chk: assert property (@(posedge clk) disable iff (rst)
    (frun && tick) |=> cnt == $past(cnt) + DW'(1));
  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!frun && tick && cnt == cmp) |=> cnt == '0);
  // R8
  flag_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(tick));
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq);
  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(flag));
endmodule

bind match_timer mt_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .frun(frun), .ien(ien_q),
  .tick(main_tick), .cnt(cnt_w), .cmp(cmp_q), .flag(flag_q), .irq(irq_q)
);

// File: tb/tb_match_timer.sv
module tb_match_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // {src[38:36], main_pre[35:24], osc_en[23], osc_pre[22:19], tick_mask[18:16], n[15:0]}
  // tick_mask bit0 = tick_bus, bit1 = tick_per, bit2 = tick_osc
  localparam logic [38:0] VEC [0:NV-1] = '{
    {3'd1, 12'd0, 1'b0, 4'd0, 3'b001, 16'd20},
    {3'd1, 12'd3, 1'b0, 4'd0, 3'b001, 16'd21},
    {3'd2, 12'd0, 1'b0, 4'd0, 3'b010, 16'd13},
    {3'd2, 12'd0, 1'b0, 4'd0, 3'b001, 16'd13},
    {3'd5, 12'd0, 1'b0, 4'd0, 3'b100, 16'd40},
    {3'd5, 12'd0, 1'b1, 4'd7, 3'b100, 16'd40},
    {3'd5, 12'd2, 1'b1, 4'd1, 3'b100, 16'd30},
    {3'd3, 12'd0, 1'b0, 4'd0, 3'b111, 16'd10},
    {3'd5, 12'd1, 1'b1, 4'd3, 3'b100, 16'd33}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_bus = 1'b0, tick_per = 1'b0, tick_osc = 1'b0;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [31:0] v, v2;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_timer dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_bus(tick_bus),
    .tick_per(tick_per), .tick_osc(tick_osc), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic run_ticks(input logic [2:0] mask, input int n);
    @(negedge clk); {tick_osc, tick_per, tick_bus} = mask;
    repeat (n) @(negedge clk);
    {tick_osc, tick_per, tick_bus} = 3'b000;
  endtask

  function automatic logic [31:0] ctl(input logic [2:0] src, input bit frun,
                                      input bit oen, input bit wt);
    return 32'(1) | (32'(wt) << 3) | (32'(src) << 6) | (32'(frun) << 9) | (32'(oen) << 10);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    foreach (VEC[i]) begin end
    rd(6'h00, v); check("R1 ctrl", v, 0);
    rd(6'h04, v); check("R1 pre", v, 0);
    rd(6'h08, v); check("R1 stat", v, 0);
    rd(6'h0C, v); check("R1 ien", v, 0);
    rd(6'h10, v); check("R1 cmp", v, 0);
    rd(6'h24, v); check("R1 cnt", v, 0);
    check("R1 irq", 32'(irq), 0);

    // R11 readback masks
    wr(6'h00, 32'hFFFF_F7FE); rd(6'h00, v); check("R11 ctrl mask", v, 32'h0000_07C8);
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); check("R11 pre mask", v, 32'h0000_FFFF);
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, v); check("R9 ien readback", v, 1);
    // R10 counter write ignored, unmapped reads zero
    wr(6'h24, 32'h1234_5678); rd(6'h24, v); check("R10 cnt write ignored", v, 0);
    wr(6'h14, 32'hFFFF_FFFF); rd(6'h14, v); check("R10 unmapped", v, 0);

    // R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0] src; logic [11:0] mp; logic oe; logic [3:0] op; logic [2:0] mk;
      int n, srcn, od, exp;
      {src, mp, oe, op, mk} = VEC[i][38:16];
      n = int'(VEC[i][15:0]);
      do_reset();
      wr(6'h04, {16'd0, op, mp});
      wr(6'h10, 32'hFFFF_FFF0);
      wr(6'h00, ctl(src, 1'b1, oe, 1'b0));
      run_ticks(mk, n);
      srcn = 0; od = 1;
      if (src == 3'd1 && mk[0]) srcn = n;
      if (src == 3'd2 && mk[1]) srcn = n;
      if (src == 3'd5 && mk[2]) begin
        od = oe ? int'(op) + 1 : 8;
        srcn = n / od;
      end
      exp = srcn / (int'(mp) + 1);
      rd(6'h24, v);
      check($sformatf("R3 R4 R5 vector %0d", i), v, 32'(exp));
    end

    // R2 hold and resume, including prescaler state
    do_reset();
    wr(6'h04, 32'd3);
    wr(6'h00, ctl(3'd1, 1'b1, 1'b0, 1'b0));
    run_ticks(3'b001, 6);                 // count 1, prescaler at 2
    wr(6'h00, ctl(3'd1, 1'b1, 1'b0, 1'b0) & ~32'd1);
    run_ticks(3'b111, 10);
    rd(6'h24, v); check("R2 held while disabled", v, 1);
    wr(6'h00, ctl(3'd1, 1'b1, 1'b0, 1'b0));
    run_ticks(3'b001, 2);                 // prescaler resumes at 2 -> one more
    rd(6'h24, v); check("R2 resume", v, 2);
    // R10 read does not disturb
    rd(6'h24, v2); check("R10 reread stable", v2, 2);

    // R11 wait bit has no effect
    do_reset();
    wr(6'h00, ctl(3'd1, 1'b1, 1'b0, 1'b1));
    run_ticks(3'b001, 7);
    rd(6'h24, v); check("R11 wait bit counts", v, 7);

    // R7 restart mode with compare 4
    do_reset();
    wr(6'h10, 32'd4);
    wr(6'h00, ctl(3'd1, 1'b0, 1'b0, 1'b0));
    run_ticks(3'b001, 12);
    rd(6'h24, v); check("R7 restart count", v, 2);
    rd(6'h08, v); check("R8 flag set", v, 1);
    check("R9 irq masked", 32'(irq), 0);
    wr(6'h0C, 32'd1);
    @(negedge clk); check("R9 irq asserted", 32'(irq), 1);
    wr(6'h0C, 32'd0);
    @(negedge clk); check("R9 irq deasserted", 32'(irq), 0);
    rd(6'h08, v); check("R9 mask keeps flag", v, 1);
    wr(6'h08, 32'd0);
    rd(6'h08, v); check("R8 write 0 no effect", v, 1);
    wr(6'h08, 32'd1);
    rd(6'h08, v); check("R8 write 1 clears", v, 0);

    // R6 free-run passes the compare value
    do_reset();
    wr(6'h10, 32'd4);
    wr(6'h00, ctl(3'd1, 1'b1, 1'b0, 1'b0));
    run_ticks(3'b001, 12);
    rd(6'h24, v); check("R6 free-run count", v, 12);
    rd(6'h08, v); check("R8 flag in free-run", v, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule